// File: doc/BRIEF.md
# Set-Associative Software-Loaded Translation Lookup

This block translates a virtual page number through a small translation buffer that software fills directly. The buffer is split into a code bank and a data bank of equal size, and each bank holds a configurable number of ways, each with a configurable number of sets. A lookup presents a page number, an access kind, a compare tag, a protection key and a no-execute flag. One entry per way is read from the bank that matches the access kind. The block checks those entries for a hit and requires that all accepted hits agree. It then decodes access rights and returns a registered result one cycle later.

Each lookup that finds an entry also writes status back into that entry. The referenced bit is always set. The changed bit is set by a granted store. When the changed bit is still clear, any other access has write permission removed from the returned rights, so the first write to a clean page faults instead of being granted. A separate write port loads whole entries. Page-table walks after a miss are left to software.

Top module: `tlbl_lookup`

## Requirements
- R1: The set is the low log2(SETS) bits of the page number. Entry index = set + way*SETS, plus WAYS*SETS when the access kind is fetch. The write port uses the same formula with `wr_code` in place of the fetch test, so code and data entries never alias.
- R2: A way hits only when all of these hold: the stored page number equals `req_vpn`; word0 bit 31 (valid) is 1; word0 bit 6 (secondary) is 0; and the stored tag {word0[30:7], word0[5:0]} equals `req_tag`.
- R3: A hit in a later way whose word1 frame [31:12], attribute [6:3] and protection [1:0] fields differ from an earlier accepted hit is ignored.
- R4: Ways are searched from 0 upward. A granted hit ends the search and becomes the chosen entry. A denied hit keeps the search going, so the chosen entry is the last accepted hit and the result is a protection fault.
- R5: Rights are returned as `rsp_prot` = {execute, write, read}. With key 0, read and write are allowed for every protection value. With key 1: 00 allows nothing, 01 and 11 allow read only, and 10 allows read and write. Execute equals read when `req_nx` is 0 and is 0 otherwise. Fetch needs execute, load (kind 1) needs read, and store (kind 2) needs write. Fetch is kind 0.
- R6: Any hit sets the referenced bit, word1 bit 8, in the chosen entry.
- R7: When the chosen entry's changed bit (word1 bit 7) is 0, a granted store sets that bit. Every other access clears the write bit of `rsp_prot`.
- R8: `rsp_result` is 0 for granted, 1 for miss and 2 for protection fault. On a miss, `rsp_word` and `rsp_prot` are 0. On a hit, `rsp_word` is the chosen entry's word1 as it was before the status update.
- R9: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high. After reset it is low, and no entry is valid.
- R10: A lookup in the cycle right after another lookup sees the status bits that the earlier lookup wrote.
- R11: A software write to an entry in the cycle after a lookup chose that entry replaces the whole entry. The pending status update for that entry is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request this cycle |
| req_vpn | input | VPN_W | Virtual page number |
| req_kind | input | 2 | 0 fetch, 1 load, 2 store |
| req_tag | input | 30 | Compare tag |
| req_key | input | 1 | Protection key |
| req_nx | input | 1 | No-execute flag |
| wr_en | input | 1 | Load an entry |
| wr_code | input | 1 | Target the code bank |
| wr_way | input | log2(WAYS) | Target way |
| wr_set | input | log2(SETS) | Target set |
| wr_vpn | input | VPN_W | Page number stored in the entry |
| wr_w0 | input | 32 | Entry word0 (valid, tag, secondary) |
| wr_w1 | input | 32 | Entry word1 (frame, status, attributes, protection) |
| rsp_valid | output | 1 | Result valid |
| rsp_result | output | 2 | Outcome code |
| rsp_word | output | 32 | Chosen entry word1 before update |
| rsp_prot | output | 3 | Returned rights {x,w,r} |

## Verification
The assertions assume that `req_kind` never carries code 3 and that `rsp_*` is read only in the cycle that `rsp_valid` marks. They also assume software never loads an entry in the same cycle as a lookup. The stimulus issues one operation per cycle, either a write or a lookup, and draws the access kind only from 0 to 2. Page numbers and tags are drawn from small pools so that hits, duplicate ways, disagreeing ways and back-to-back lookups of the same entry occur often.

// File: rtl/tlbl_pkg.sv
package tlbl_pkg;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2
  } acc_e;

  typedef enum logic [1:0] {
    RES_GRANT = 2'd0,
    RES_MISS  = 2'd1,
    RES_PROT  = 2'd2
  } res_e;

  localparam int TAG_W    = 30;
  localparam int W0_VALID = 31;
  localparam int W0_SEC   = 6;
  localparam int W1_REF   = 8;
  localparam int W1_CHG   = 7;
  // frame [31:12], attributes [6:3], protection [1:0]
  localparam logic [31:0] AGREE_MASK = 32'hFFFF_F07B;

  function automatic logic [TAG_W-1:0] tag_of(logic [31:0] w0);
    return {w0[30:7], w0[5:0]};
  endfunction

  // returns {execute, write, read}
  function automatic logic [2:0] perm_decode(logic key, logic [1:0] pp, logic nx);
    logic r, w;
    if (!key) begin
      r = 1'b1;
      w = 1'b1;
    end else begin
      unique case (pp)
        2'b00:   begin r = 1'b0; w = 1'b0; end
        2'b10:   begin r = 1'b1; w = 1'b1; end
        default: begin r = 1'b1; w = 1'b0; end
      endcase
    end
    return {r & ~nx, w, r};
  endfunction

  function automatic logic perm_allows(logic [2:0] p, acc_e kind);
    unique case (kind)
      ACC_FETCH: return p[2];
      ACC_LOAD:  return p[0];
      ACC_STORE: return p[1];
      default:   return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/tlbl_store.sv
module tlbl_store #(
  parameter int VPN_W = 20,
  parameter int WAYS  = 2,
  parameter int SETS  = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [$clog2(2*WAYS*SETS)-1:0] wr_idx,
  input  logic [VPN_W-1:0]             wr_vpn,
  input  logic [31:0]                  wr_w0,
  input  logic [31:0]                  wr_w1,
  input  logic                         upd_en,
  input  logic [$clog2(2*WAYS*SETS)-1:0] upd_idx,
  input  logic [31:0]                  upd_bits,
  input  logic [$clog2(2*WAYS*SETS)-1:0] rd_idx [WAYS],
  output logic [VPN_W-1:0]             ent_vpn [WAYS],
  output logic [31:0]                  ent_w0 [WAYS],
  output logic [31:0]                  ent_w1 [WAYS],
  output logic                         upd_pend
);
  localparam int DEPTH = 2 * WAYS * SETS;
  localparam int IDX_W = $clog2(DEPTH);

  logic [VPN_W-1:0] mem_vpn [DEPTH];
  logic [31:0]      mem_w0  [DEPTH];
  logic [31:0]      mem_w1  [DEPTH];

  logic             pend_v;
  logic [IDX_W-1:0] pend_idx;
  logic [31:0]      pend_bits;
  logic             pend_lost;

  // a software write to the same entry wins over the status update
  assign pend_lost = wr_en && (wr_idx == pend_idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        mem_vpn[i] <= '0;
        mem_w0[i]  <= '0;
        mem_w1[i]  <= '0;
      end
      pend_v    <= 1'b0;
      pend_idx  <= '0;
      pend_bits <= '0;
    end else begin
      pend_v    <= upd_en;
      pend_idx  <= upd_idx;
      pend_bits <= upd_bits;
      if (wr_en) begin
        mem_vpn[wr_idx] <= wr_vpn;
        mem_w0[wr_idx]  <= wr_w0;
        mem_w1[wr_idx]  <= wr_w1;
      end
      if (pend_v && !pend_lost) begin
        mem_w1[pend_idx] <= mem_w1[pend_idx] | pend_bits;
      end
    end
  end

  for (genvar r = 0; r < WAYS; r++) begin : g_rd
    logic fwd;
    assign fwd        = pend_v && (pend_idx == rd_idx[r]);
    assign ent_vpn[r] = mem_vpn[rd_idx[r]];
    assign ent_w0[r]  = mem_w0[rd_idx[r]];
    assign ent_w1[r]  = mem_w1[rd_idx[r]] | (fwd ? pend_bits : 32'h0);
  end

  assign upd_pend = pend_v;

endmodule

// File: rtl/tlbl_search.sv
module tlbl_search
  import tlbl_pkg::*;
#(
  parameter int VPN_W = 20,
  parameter int WAYS  = 2
) (
  input  logic [VPN_W-1:0]        vpn,
  input  logic [TAG_W-1:0]        tag,
  input  logic                    key,
  input  logic                    nx,
  input  acc_e                    kind,
  input  logic [VPN_W-1:0]        ent_vpn [WAYS],
  input  logic [31:0]             ent_w0 [WAYS],
  input  logic [31:0]             ent_w1 [WAYS],
  output logic [WAYS-1:0]         way_hit,
  output logic                    found,
  output logic                    granted,
  output logic [$clog2(WAYS)-1:0] best_way,
  output logic [31:0]             best_w1,
  output logic [2:0]              best_prot
);
  localparam int WW = $clog2(WAYS);

  logic          s_found [WAYS+1];
  logic          s_done  [WAYS+1];
  logic          s_grant [WAYS+1];
  logic [WW-1:0] s_way   [WAYS+1];
  logic [31:0]   s_w1    [WAYS+1];
  logic [2:0]    s_prot  [WAYS+1];

  assign s_found[0] = 1'b0;
  assign s_done[0]  = 1'b0;
  assign s_grant[0] = 1'b0;
  assign s_way[0]   = '0;
  assign s_w1[0]    = '0;
  assign s_prot[0]  = '0;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic       raw_hit, agree, take, ok;
    logic [2:0] p;
    assign raw_hit = ent_w0[w][W0_VALID] && !ent_w0[w][W0_SEC] &&
                     (ent_vpn[w] == vpn) && (tag_of(ent_w0[w]) == tag);
    assign agree   = !s_found[w] || (((s_w1[w] ^ ent_w1[w]) & AGREE_MASK) == 32'h0);
    assign take    = raw_hit && agree && !s_done[w];
    assign p       = perm_decode(key, ent_w1[w][1:0], nx);
    assign ok      = perm_allows(p, kind);
    assign way_hit[w] = raw_hit;

    assign s_found[w+1] = s_found[w] | take;
    assign s_done[w+1]  = s_done[w] | (take & ok);
    assign s_grant[w+1] = take ? ok : s_grant[w];
    assign s_way[w+1]   = take ? WW'(w) : s_way[w];
    assign s_w1[w+1]    = take ? ent_w1[w] : s_w1[w];
    assign s_prot[w+1]  = take ? p : s_prot[w];
  end

  assign found     = s_found[WAYS];
  assign granted   = s_grant[WAYS];
  assign best_way  = s_way[WAYS];
  assign best_w1   = s_w1[WAYS];
  assign best_prot = s_prot[WAYS];

endmodule

// File: rtl/tlbl_lookup.sv
module tlbl_lookup
  import tlbl_pkg::*;
#(
  parameter int VPN_W = 20,
  parameter int WAYS  = 2,
  parameter int SETS  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic [VPN_W-1:0]        req_vpn,
  input  logic [1:0]              req_kind,
  input  logic [29:0]             req_tag,
  input  logic                    req_key,
  input  logic                    req_nx,
  input  logic                    wr_en,
  input  logic                    wr_code,
  input  logic [$clog2(WAYS)-1:0] wr_way,
  input  logic [$clog2(SETS)-1:0] wr_set,
  input  logic [VPN_W-1:0]        wr_vpn,
  input  logic [31:0]             wr_w0,
  input  logic [31:0]             wr_w1,
  output logic                    rsp_valid,
  output logic [1:0]              rsp_result,
  output logic [31:0]             rsp_word,
  output logic [2:0]              rsp_prot
);
  localparam int SET_W = $clog2(SETS);
  localparam int WW    = $clog2(WAYS);
  localparam int BANK  = WAYS * SETS;
  localparam int DEPTH = 2 * BANK;
  localparam int IDX_W = $clog2(DEPTH);

  function automatic logic [IDX_W-1:0] entry_index(logic code, logic [WW-1:0] way,
                                                   logic [SET_W-1:0] set);
    return (code ? IDX_W'(BANK) : IDX_W'(0)) + IDX_W'(way) * IDX_W'(SETS) + IDX_W'(set);
  endfunction

  acc_e             kind;
  logic             is_store;
  logic [IDX_W-1:0] rd_idx [WAYS];
  logic [IDX_W-1:0] wr_idx;
  logic [VPN_W-1:0] ent_vpn [WAYS];
  logic [31:0]      ent_w0 [WAYS];
  logic [31:0]      ent_w1 [WAYS];
  logic [WAYS-1:0]  way_hit;
  logic             found, granted;
  logic [WW-1:0]    best_way;
  logic [31:0]      best_w1;
  logic [2:0]       best_prot;
  logic             clean, first_write, upd_en, upd_pend;
  logic [31:0]      upd_bits;
  logic [IDX_W-1:0] upd_idx;
  logic [2:0]       ret_prot;
  res_e             res_now;

  assign kind     = acc_e'(req_kind);
  assign is_store = (kind == ACC_STORE);
  assign wr_idx   = entry_index(wr_code, wr_way, wr_set);

  for (genvar w = 0; w < WAYS; w++) begin : g_idx
    assign rd_idx[w] = entry_index(kind == ACC_FETCH, WW'(w), req_vpn[SET_W-1:0]);
  end

  tlbl_store #(.VPN_W(VPN_W), .WAYS(WAYS), .SETS(SETS)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn(wr_vpn), .wr_w0(wr_w0), .wr_w1(wr_w1),
    .upd_en(upd_en), .upd_idx(upd_idx), .upd_bits(upd_bits),
    .rd_idx(rd_idx), .ent_vpn(ent_vpn), .ent_w0(ent_w0), .ent_w1(ent_w1),
    .upd_pend(upd_pend)
  );

  tlbl_search #(.VPN_W(VPN_W), .WAYS(WAYS)) u_search (
    .vpn(req_vpn), .tag(req_tag), .key(req_key), .nx(req_nx), .kind(kind),
    .ent_vpn(ent_vpn), .ent_w0(ent_w0), .ent_w1(ent_w1),
    .way_hit(way_hit), .found(found), .granted(granted), .best_way(best_way),
    .best_w1(best_w1), .best_prot(best_prot)
  );

  // status write-back and first-write downgrade
  assign clean       = !best_w1[W1_CHG];
  assign first_write = clean && is_store && granted;
  assign upd_en      = req_valid && found;
  assign upd_idx     = rd_idx[best_way];
  assign upd_bits    = (32'h1 << W1_REF) | (first_write ? (32'h1 << W1_CHG) : 32'h0);
  assign ret_prot    = (clean && !first_write) ? (best_prot & 3'b101) : best_prot;
  assign res_now     = !found ? RES_MISS : (granted ? RES_GRANT : RES_PROT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_result <= RES_MISS;
      rsp_word   <= '0;
      rsp_prot   <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_result <= res_now;
        rsp_word   <= found ? best_w1 : 32'h0;
        rsp_prot   <= found ? ret_prot : 3'b000;
      end
    end
  end

endmodule

// File: rtl/tlbl_lookup_chk.sv
module tlbl_lookup_chk
  import tlbl_pkg::*;
#(
  parameter int WAYS = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic [1:0]      req_kind,
  input logic [WAYS-1:0] way_hit,
  input logic            upd_pend,
  input logic            rsp_valid,
  input logic [1:0]      rsp_result,
  input logic [31:0]     rsp_word,
  input logic [2:0]      rsp_prot
);

  // R9
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R9
  rsp_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid));

  // R8
  result_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_result != 2'd3);

  // R8
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_result == RES_MISS |-> rsp_prot == 3'b000 && rsp_word == 32'h0);

  // R2
  no_hit_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && way_hit == '0 |=> rsp_result == RES_MISS);

  // R6
  status_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> upd_pend == (rsp_result != RES_MISS));

  // R7
  store_keeps_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_result == RES_GRANT && $past(req_kind) == ACC_STORE |-> rsp_prot[1]);

  // R7
  clean_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_result != RES_MISS && !rsp_word[W1_CHG] &&
    !(rsp_result == RES_GRANT && $past(req_kind) == ACC_STORE) |-> !rsp_prot[1]);

  // R5
  fetch_needs_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_result == RES_GRANT && $past(req_kind) == ACC_FETCH |-> rsp_prot[2]);

endmodule

bind tlbl_lookup tlbl_lookup_chk #(.WAYS(WAYS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
  .way_hit(way_hit), .upd_pend(upd_pend), .rsp_valid(rsp_valid),
  .rsp_result(rsp_result), .rsp_word(rsp_word), .rsp_prot(rsp_prot)
);

// File: tb/tlbl_lookup_tb.sv
module tlbl_lookup_tb_top;
  localparam int NENT = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [19:0] req_vpn = '0;
  logic [1:0]  req_kind = '0;
  logic [29:0] req_tag = '0;
  logic        req_key = 1'b0;
  logic        req_nx = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_code = 1'b0;
  logic [0:0]  wr_way = '0;
  logic [3:0]  wr_set = '0;
  logic [19:0] wr_vpn = '0;
  logic [31:0] wr_w0 = '0;
  logic [31:0] wr_w1 = '0;
  logic        rsp_valid;
  logic [1:0]  rsp_result;
  logic [31:0] rsp_word;
  logic [2:0]  rsp_prot;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [19:0] m_vpn [NENT];
  logic [31:0] m_w0  [NENT];
  logic [31:0] m_w1  [NENT];
  logic [19:0] vpn_pool [8];
  logic [29:0] tag_pool [4];

  always #10 clk = ~clk;

  tlbl_lookup dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vpn(req_vpn),
    .req_kind(req_kind), .req_tag(req_tag), .req_key(req_key), .req_nx(req_nx),
    .wr_en(wr_en), .wr_code(wr_code), .wr_way(wr_way), .wr_set(wr_set),
    .wr_vpn(wr_vpn), .wr_w0(wr_w0), .wr_w1(wr_w1), .rsp_valid(rsp_valid),
    .rsp_result(rsp_result), .rsp_word(rsp_word), .rsp_prot(rsp_prot)
  );

  function automatic logic [31:0] mk_w0(logic v, logic sec, logic [29:0] t);
    return {v, t[29:6], sec, t[5:0]};
  endfunction

  function automatic logic [31:0] mk_w1(logic [19:0] frame, logic rf, logic ch,
                                       logic [3:0] attr, logic [1:0] pp);
    return {frame, 3'b000, rf, ch, attr, 1'b0, pp};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_lookup(input logic [19:0] vpn, input logic [1:0] kind,
                              input logic [29:0] tag, input logic key, input logic nx,
                              output logic [1:0] res, output logic [31:0] word,
                              output logic [2:0] prot);
    int chosen, i;
    logic found, granted, rd, wr, ex, ok;
    logic [31:0] first;
    chosen = -1; found = 0; granted = 0; first = 0; prot = 0; word = 0;
    for (int w = 0; w < 2; w++) begin
      i = (kind == 2'd0 ? 32 : 0) + w * 16 + int'(vpn[3:0]);
      if (m_vpn[i] !== vpn || !m_w0[i][31] || m_w0[i][6] ||
          {m_w0[i][30:7], m_w0[i][5:0]} !== tag) continue;
      if (found && ((m_w1[i] ^ first) & 32'hFFFFF07B) != 0) continue;
      found = 1; first = m_w1[i]; chosen = i;
      rd = !key || m_w1[i][1:0] != 2'b00;
      wr = !key || m_w1[i][1:0] == 2'b10;
      ex = rd && !nx;
      prot = {ex, wr, rd};
      ok = (kind == 2'd0) ? ex : (kind == 2'd1) ? rd : wr;
      if (ok) begin granted = 1; break; end
    end
    if (found) begin
      word = m_w1[chosen];
      m_w1[chosen][8] = 1'b1;
      if (!word[7]) begin
        if (kind == 2'd2 && granted) m_w1[chosen][7] = 1'b1;
        else prot[1] = 1'b0;
      end
      res = granted ? 2'd0 : 2'd2;
    end else begin
      res = 2'd1;
    end
  endtask

  task automatic sw_write(logic code, logic way, logic [3:0] set, logic [19:0] vpn,
                          logic [31:0] w0, logic [31:0] w1);
    int i;
    @(negedge clk);
    wr_en = 1'b1; wr_code = code; wr_way = way; wr_set = set;
    wr_vpn = vpn; wr_w0 = w0; wr_w1 = w1;
    i = (code ? 32 : 0) + (way ? 16 : 0) + int'(set);
    m_vpn[i] = vpn; m_w0[i] = w0; m_w1[i] = w1;
    @(posedge clk);
    #2 wr_en = 1'b0;
  endtask

  task automatic look(string req, logic [19:0] vpn, logic [1:0] kind, logic [29:0] tag,
                      logic key, logic nx);
    logic [1:0] e_res;
    logic [31:0] e_word;
    logic [2:0] e_prot;
    @(negedge clk);
    req_valid = 1'b1; req_vpn = vpn; req_kind = kind; req_tag = tag;
    req_key = key; req_nx = nx;
    model_lookup(vpn, kind, tag, key, nx, e_res, e_word, e_prot);
    @(posedge clk);
    #2;
    chk({req, " valid R9"}, 32'(rsp_valid), 32'd1);
    chk({req, " result R8"}, 32'(rsp_result), 32'(e_res));
    chk({req, " word R6"}, rsp_word, e_word);
    chk({req, " prot R5"}, 32'(rsp_prot), 32'(e_prot));
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R9: watchdog expired, actual hang expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [19:0] p, q, v;
    logic [29:0] t;
    void'($urandom(32'd4242));
    for (int i = 0; i < NENT; i++) begin m_vpn[i] = '0; m_w0[i] = '0; m_w1[i] = '0; end
    for (int i = 0; i < 8; i++) vpn_pool[i] = 20'($urandom);
    for (int i = 0; i < 4; i++) tag_pool[i] = 30'($urandom);

    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    chk("R9 reset valid", 32'(rsp_valid), 32'd0);
    chk("R9 reset prot", 32'(rsp_prot), 32'd0);

    p = 20'h12345; t = 30'h0ABCDE1;
    look("R9 empty", p, 2'd1, t, 1'b0, 1'b0);
    chk("R9 no entry valid after reset", 32'(rsp_result), 32'd1);

    // R1: data entry invisible to fetch
    sw_write(1'b0, 1'b0, 4'h5, p, mk_w0(1, 0, t), mk_w1(20'hAAAAA, 0, 0, 4'h3, 2'b01));
    look("R1 fetch vs data", p, 2'd0, t, 1'b0, 1'b0);
    chk("R1 fetch misses data bank", 32'(rsp_result), 32'd1);
    // R7: clean page load loses write
    look("R7 clean load", p, 2'd1, t, 1'b0, 1'b0);
    chk("R7 clean load prot", 32'(rsp_prot), 32'b101);
    // R10: back-to-back sees referenced bit
    look("R10 b2b", p, 2'd1, t, 1'b0, 1'b0);
    chk("R10 referenced forwarded", 32'(rsp_word[8]), 32'd1);
    look("R7 first store", p, 2'd2, t, 1'b0, 1'b0);
    chk("R7 store granted", 32'(rsp_prot), 32'b111);
    look("R7 after store", p, 2'd1, t, 1'b0, 1'b0);
    chk("R7 changed set", 32'(rsp_word[7]), 32'd1);
    // R2: tag, secondary, validity
    look("R2 tag", p, 2'd1, t ^ 30'h1, 1'b0, 1'b0);
    chk("R2 wrong tag miss", 32'(rsp_result), 32'd1);
    sw_write(1'b1, 1'b1, 4'h5, p, mk_w0(1, 1, t), mk_w1(20'h11111, 0, 0, 4'h0, 2'b10));
    look("R2 secondary", p, 2'd0, t, 1'b0, 1'b0);
    chk("R2 secondary miss", 32'(rsp_result), 32'd1);
    sw_write(1'b1, 1'b0, 4'h5, p, mk_w0(0, 0, t), mk_w1(20'h11111, 0, 0, 4'h0, 2'b10));
    look("R2 invalid", p, 2'd0, t, 1'b0, 1'b0);
    chk("R2 invalid miss", 32'(rsp_result), 32'd1);
    // R11: write after lookup drops status update
    look("R11 lookup", p, 2'd1, t, 1'b0, 1'b0);
    sw_write(1'b0, 1'b0, 4'h5, p, mk_w0(1, 0, t), mk_w1(20'hAAAAA, 0, 0, 4'h3, 2'b01));
    look("R11 reread", p, 2'd1, t, 1'b0, 1'b0);
    chk("R11 referenced cleared", 32'(rsp_word[8]), 32'd0);
    // R4: denied hit continues, later agreeing entry chosen
    q = 20'h00007;
    sw_write(1'b1, 1'b0, 4'h7, q, mk_w0(1, 0, t), mk_w1(20'h0BEEF, 0, 0, 4'h5, 2'b01));
    sw_write(1'b1, 1'b1, 4'h7, q, mk_w0(1, 0, t), mk_w1(20'h0BEEF, 0, 1, 4'h5, 2'b01));
    look("R4 denied", q, 2'd0, t, 1'b0, 1'b1);
    chk("R4 last agreeing chosen", 32'(rsp_prot), 32'b011);
    sw_write(1'b0, 1'b0, 4'h7, q, mk_w0(1, 0, t), mk_w1(20'h0BEEF, 0, 0, 4'h5, 2'b01));
    sw_write(1'b0, 1'b1, 4'h7, q, mk_w0(1, 0, t), mk_w1(20'h0BEEF, 0, 1, 4'h5, 2'b01));
    look("R4 granted", q, 2'd1, t, 1'b0, 1'b0);
    chk("R4 grant stops at way 0", 32'(rsp_prot), 32'b101);
    // R3: disagreeing later way ignored
    v = 20'h00009;
    sw_write(1'b0, 1'b0, 4'h9, v, mk_w0(1, 0, t), mk_w1(20'h00123, 0, 1, 4'h0, 2'b00));
    sw_write(1'b0, 1'b1, 4'h9, v, mk_w0(1, 0, t), mk_w1(20'h00123, 0, 1, 4'h0, 2'b10));
    look("R3 disagree", v, 2'd1, t, 1'b1, 1'b0);
    chk("R3 protection fault", 32'(rsp_result), 32'd2);
    // R5: key 1 read-only
    sw_write(1'b0, 1'b1, 4'h9, v, mk_w0(0, 0, t), 32'h0);
    sw_write(1'b0, 1'b0, 4'h9, v, mk_w0(1, 0, t), mk_w1(20'h00123, 0, 1, 4'h0, 2'b01));
    look("R5 ro store", v, 2'd2, t, 1'b1, 1'b0);
    chk("R5 store denied", 32'(rsp_result), 32'd2);
    look("R5 ro load", v, 2'd1, t, 1'b1, 1'b0);
    chk("R5 read-only rights", 32'(rsp_prot), 32'b101);

    // constrained random mix, R1..R11 against the model
    for (int n = 0; n < 3000; n++) begin
      if ($urandom_range(0, 9) < 3) begin
        logic [19:0] rv;
        logic [3:0]  rs;
        logic        rc, rw;
        logic [31:0] w0, w1;
        rv = vpn_pool[$urandom_range(0, 7)];
        rs = ($urandom_range(0, 9) < 8) ? rv[3:0] : 4'($urandom);
        rc = 1'($urandom); rw = 1'($urandom);
        w0 = mk_w0($urandom_range(0, 9) != 0, $urandom_range(0, 9) == 0,
                   tag_pool[$urandom_range(0, 3)]);
        w1 = mk_w1($urandom_range(0, 1) ? 20'h0F00D : 20'h0CAFE, 1'($urandom),
                   1'($urandom), $urandom_range(0, 1) ? 4'h2 : 4'h9, 2'($urandom));
        sw_write(rc, rw, rs, rv, w0, w1);
        if ($urandom_range(0, 2) == 0) begin
          if ($urandom_range(0, 3) == 0) w1[1:0] = w1[1:0] ^ 2'b10;
          else w1[8:7] = 2'($urandom);
          sw_write(rc, !rw, rs, rv, w0, w1);
        end
      end else begin
        look("random", vpn_pool[$urandom_range(0, 7)], 2'($urandom_range(0, 2)),
             tag_pool[$urandom_range(0, 3)], 1'($urandom), $urandom_range(0, 3) == 0);
      end
    end

    @(negedge clk);
    chk("R9 idle valid", 32'(rsp_valid), 32'd0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule